// File: doc/BRIEF.md
# Fully Associative Lookup Buffer

This block is a small tag store in which any entry can hold any tag. Address translation is the typical use. A request carries only a tag and a word offset. No request bits pick an entry. Instead, every entry compares its stored tag against the requested tag at once, through its own comparator. Within the same cycle the block reports a hit, the index of the matching entry, and the payload word at the requested offset.

A second port inserts a tag together with a full payload line. The target entry is chosen in this order:

1. An entry that already holds the tag is updated in place.
2. Otherwise, the lowest-numbered empty entry is filled.
3. When the buffer is full, a Clock policy picks the victim. Each entry has a reference bit, and a rotating hand walks the entries.

A flush input empties the whole buffer in one cycle.

Top module: `assoc_lookup_buf`

## Requirements
- R1: While `lookupValid` is high and a valid entry holds `lookupTag`, `hit` is 1 and `hitIndex` names that entry in the same cycle (no register on the path). Otherwise `hit`, `hitIndex` and `hitWord` are all 0.
- R2: On a hit, `hitWord` is word `lookupOffset` of the matching line. Word 0 is the least significant WORD_W bits of `insertLine`.
- R3: Any tag may be placed in any entry. Tags that share all of their low bits occupy separate entries and can all be found.
- R4: An insert of a tag that is not present, while some entry is empty, writes the lowest-numbered empty entry.
- R5: An insert of a tag that is already present overwrites that entry's payload. No other entry is changed or evicted, even when the buffer is full.
- R6: No tag is ever held by more than one valid entry.
- R7: An insert of a new tag into a full buffer uses Clock replacement, which works as follows:
  - The hand starts at entry 0 after reset.
  - A newly written entry gets a clear reference bit.
  - A lookup hit, or an in-place update, sets the entry's reference bit.
  - Starting at the hand, set bits are cleared and passed over. The first entry with a clear bit is the victim. If every bit is set, all are cleared and the entry at the hand is the victim.
  - The hand then moves to the entry after the victim.
- R8: A `flush` pulse invalidates every entry at the next clock edge. Flush takes priority over an insert in the same cycle, and that insert is dropped.
- R9: While `lookupValid` is low, `hit` stays 0 whatever the tag inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every entry |
| lookupValid | input | 1 | Lookup request present |
| lookupTag | input | TAG_W | Tag searched for |
| lookupOffset | input | clog2(LINE_WORDS) | Word selected in the matching line |
| hit | output | 1 | A valid entry holds the tag |
| hitIndex | output | clog2(ENTRIES) | Index of the matching entry |
| hitWord | output | WORD_W | Selected payload word |
| insertValid | input | 1 | Insert request present |
| insertTag | input | TAG_W | Tag to write |
| insertLine | input | LINE_WORDS*WORD_W | Payload line to write |

## Verification
The state that is hardest to reach is an eviction sweep that passes over some set reference bits and stops at a clear one part-way round the ring. Reaching it requires that the buffer is full, that the hand has already moved off entry 0, and that the bits ahead of the hand are chosen by hand. The stimulus fills every entry and touches all of them, so the first eviction clears all bits and takes entry 0. It then re-touches exactly two entries just ahead of the hand. The next insert must sweep past those two and land on the third. Lookups issued as checks set bits themselves, so the expected victims account for every check that hits.

// File: rtl/albPkg.sv
package albPkg;
  typedef struct packed {
    logic wrEn;
    logic clearAll;
  } albStrobeT;
endpackage

// File: rtl/albDatapath.sv
module albDatapath
  import albPkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W = 10,
  parameter int WORD_W = 8,
  parameter int LINE_WORDS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  albStrobeT strobe,
  input  logic [$clog2(ENTRIES)-1:0] wrIdx,
  input  logic [TAG_W-1:0] insertTag,
  input  logic [LINE_WORDS*WORD_W-1:0] insertLine,
  input  logic lookupValid,
  input  logic [TAG_W-1:0] lookupTag,
  input  logic [$clog2(LINE_WORDS)-1:0] lookupOffset,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] lookMatch,
  output logic [ENTRIES-1:0] insMatch,
  output logic hit,
  output logic [$clog2(ENTRIES)-1:0] hitIndex,
  output logic [WORD_W-1:0] hitWord
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int LINE_W = LINE_WORDS * WORD_W;

  logic [TAG_W-1:0] tagMem [ENTRIES];
  logic [LINE_W-1:0] lineMem [ENTRIES];
  logic [IDX_W-1:0] hitIdxC;
  logic [LINE_W-1:0] hitLine;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAll) begin
      validVec <= '0;
    end else if (strobe.wrEn) begin
      validVec[wrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn && !strobe.clearAll) begin
      tagMem[wrIdx] <= insertTag;
      lineMem[wrIdx] <= insertLine;
    end
  end

  // one comparator pair per entry, all working concurrently
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign lookMatch[e] = lookupValid && validVec[e] && (tagMem[e] == lookupTag);
    assign insMatch[e]  = validVec[e] && (tagMem[e] == insertTag);
  end

  always_comb begin
    hitIdxC = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookMatch[i]) hitIdxC = IDX_W'(i);
    end
  end

  assign hit = |lookMatch;
  assign hitIndex = hitIdxC;
  assign hitLine = lineMem[hitIdxC];
  assign hitWord = hit ? hitLine[int'(lookupOffset)*WORD_W +: WORD_W] : '0;

  // R6
  single_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(insMatch));
  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (validVec == '0));
  // R4
  write_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !strobe.clearAll) |=> validVec[$past(wrIdx)]);
  // R9
  hit_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !hit);
endmodule

// File: rtl/albCtrl.sv
module albCtrl
  import albPkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic flush,
  input  logic insertValid,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] lookMatch,
  input  logic [ENTRIES-1:0] insMatch,
  output albStrobeT strobe,
  output logic [$clog2(ENTRIES)-1:0] wrIdx
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] refBits, refNext, sweepClr;
  logic [IDX_W-1:0] hand, victimIdx, freeIdx, presentIdx, sweepPos;
  logic present, freeAny, found, evict;

  always_comb begin
    freeIdx = '0;
    presentIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) freeIdx = IDX_W'(i);
      if (insMatch[i]) presentIdx = IDX_W'(i);
    end
  end

  assign present = |insMatch;
  assign freeAny = ~&validVec;

  // clock sweep: walk from the hand, clear set bits, stop on a clear one
  always_comb begin
    found = 1'b0;
    victimIdx = hand;
    sweepClr = '0;
    sweepPos = hand;
    for (int k = 0; k < ENTRIES; k++) begin
      sweepPos = hand + IDX_W'(k);
      if (!found) begin
        if (!refBits[sweepPos]) begin
          found = 1'b1;
          victimIdx = sweepPos;
        end else begin
          sweepClr[sweepPos] = 1'b1;
        end
      end
    end
  end

  assign evict = insertValid && !flush && !present && !freeAny;
  assign wrIdx = present ? presentIdx : (freeAny ? freeIdx : victimIdx);
  assign strobe.wrEn = insertValid && !flush;
  assign strobe.clearAll = flush;

  always_comb begin
    refNext = refBits;
    if (evict) refNext = refNext & ~sweepClr;
    refNext = refNext | lookMatch;
    if (strobe.wrEn) refNext[wrIdx] = present;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      refBits <= '0;
    end else begin
      refBits <= refNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hand <= '0;
    end else if (evict) begin
      hand <= victimIdx + IDX_W'(1);
    end
  end

  // R4
  free_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !present && freeAny) |-> !validVec[wrIdx]);
  // R5
  update_in_place_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && present) |-> insMatch[wrIdx]);
  // R7
  hand_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(insertValid && !flush && !present && validVec == '1) |=> $stable(hand));
endmodule

// File: rtl/assoc_lookup_buf.sv
module assoc_lookup_buf
  import albPkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W = 10,
  parameter int WORD_W = 8,
  parameter int LINE_WORDS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic flush,
  input  logic lookupValid,
  input  logic [TAG_W-1:0] lookupTag,
  input  logic [$clog2(LINE_WORDS)-1:0] lookupOffset,
  output logic hit,
  output logic [$clog2(ENTRIES)-1:0] hitIndex,
  output logic [WORD_W-1:0] hitWord,
  input  logic insertValid,
  input  logic [TAG_W-1:0] insertTag,
  input  logic [LINE_WORDS*WORD_W-1:0] insertLine
);
  localparam int IDX_W = $clog2(ENTRIES);

  albStrobeT strobe;
  logic [IDX_W-1:0] wrIdx;
  logic [ENTRIES-1:0] validVec, lookMatch, insMatch;

  albCtrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush), .insertValid(insertValid),
    .validVec(validVec), .lookMatch(lookMatch), .insMatch(insMatch),
    .strobe(strobe), .wrIdx(wrIdx)
  );

  albDatapath #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .WORD_W(WORD_W),
                .LINE_WORDS(LINE_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx),
    .insertTag(insertTag), .insertLine(insertLine),
    .lookupValid(lookupValid), .lookupTag(lookupTag),
    .lookupOffset(lookupOffset), .validVec(validVec),
    .lookMatch(lookMatch), .insMatch(insMatch), .hit(hit),
    .hitIndex(hitIndex), .hitWord(hitWord)
  );
endmodule

// File: tb/test_assoc_lookup_buf.sv
`timescale 1ns/1ps
module test_assoc_lookup_buf;
  localparam int ENTRIES = 8;
  localparam int TAG_W = 10;
  localparam int WORD_W = 8;
  localparam int LINE_WORDS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic lookupValid = 1'b0;
  logic [TAG_W-1:0] lookupTag = '0;
  logic [1:0] lookupOffset = '0;
  logic hit;
  logic [2:0] hitIndex;
  logic [WORD_W-1:0] hitWord;
  logic insertValid = 1'b0;
  logic [TAG_W-1:0] insertTag = '0;
  logic [LINE_WORDS*WORD_W-1:0] insertLine = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assoc_lookup_buf i_assoc_lookup_buf (
    .clk(clk), .rstN(rstN), .flush(flush), .lookupValid(lookupValid),
    .lookupTag(lookupTag), .lookupOffset(lookupOffset), .hit(hit),
    .hitIndex(hitIndex), .hitWord(hitWord), .insertValid(insertValid),
    .insertTag(insertTag), .insertLine(insertLine)
  );

  function automatic logic [TAG_W-1:0] tagOf(int i);
    return TAG_W'(i * 64 + 5);
  endfunction

  function automatic logic [WORD_W-1:0] wordOf(logic [TAG_W-1:0] t, int w, int salt);
    return WORD_W'(t[7:0] + w * 8'h11 + salt * 8'h40);
  endfunction

  function automatic logic [LINE_WORDS*WORD_W-1:0] lineOf(logic [TAG_W-1:0] t, int salt);
    logic [LINE_WORDS*WORD_W-1:0] l;
    for (int w = 0; w < LINE_WORDS; w++) l[w*WORD_W +: WORD_W] = wordOf(t, w, salt);
    return l;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    lookupValid = 1'b0; insertValid = 1'b0; flush = 1'b0;
  endtask

  task automatic doInsert(logic [TAG_W-1:0] t, int salt);
    @(negedge clk);
    lookupValid = 1'b0; flush = 1'b0;
    insertValid = 1'b1; insertTag = t; insertLine = lineOf(t, salt);
    @(negedge clk);
    insertValid = 1'b0;
  endtask

  task automatic expectHit(logic [TAG_W-1:0] t, int idx, int off, int salt, string req);
    @(negedge clk);
    insertValid = 1'b0; flush = 1'b0;
    lookupValid = 1'b1; lookupTag = t; lookupOffset = 2'(off);
    #1;
    chk(hit == 1'b1, {req, " hit"}, int'(hit), 1);
    chk(int'(hitIndex) == idx, {req, " index"}, int'(hitIndex), idx);
    chk(hitWord == wordOf(t, off, salt), {req, " word"}, int'(hitWord), int'(wordOf(t, off, salt)));
  endtask

  task automatic expectMiss(logic [TAG_W-1:0] t, string req);
    @(negedge clk);
    insertValid = 1'b0; flush = 1'b0;
    lookupValid = 1'b1; lookupTag = t; lookupOffset = 2'd1;
    #1;
    chk(hit == 1'b0, {req, " no hit"}, int'(hit), 0);
    chk(hitIndex == '0 && hitWord == '0, {req, " zero outputs"}, int'(hitWord), 0);
  endtask

  task automatic resetTest();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expectMiss(tagOf(0), "R1 reset");
  endtask

  task automatic fillTest();
    for (int i = 0; i < ENTRIES; i++) doInsert(tagOf(i), 0);
    // R3 R4: shared low bits, lowest free entry each time
    for (int i = 0; i < ENTRIES; i++) expectHit(tagOf(i), i, i % LINE_WORDS, 0, "R3 R4 fill");
    // R2 every offset of one line
    for (int w = 0; w < LINE_WORDS; w++) expectHit(tagOf(6), 6, w, 0, "R2 offset");
    expectMiss(10'h3A5, "R1 unknown tag");
  endtask

  task automatic gateTest();
    @(negedge clk);
    lookupValid = 1'b0; lookupTag = tagOf(2); lookupOffset = 2'd0;
    #1;
    chk(hit == 1'b0, "R9 lookupValid low", int'(hit), 0);
  endtask

  task automatic updateTest();
    doInsert(tagOf(3), 1);
    expectHit(tagOf(3), 3, 2, 1, "R5 updated payload");
    for (int i = 0; i < ENTRIES; i++)
      if (i != 3) expectHit(tagOf(i), i, 0, 0, "R5 others kept");
  endtask

  task automatic clockTest();
    // all reference bits are set: full sweep, victim is entry 0, hand -> 1
    doInsert(10'h3F0, 2);
    expectHit(10'h3F0, 0, 1, 2, "R7 first eviction");
    expectMiss(tagOf(0), "R7 old entry 0 gone");
    // entry 1 bit was cleared by the sweep: taken at once, hand -> 2
    doInsert(10'h3F1, 2);
    expectHit(10'h3F1, 1, 3, 2, "R7 second eviction");
    expectMiss(tagOf(1), "R7 old entry 1 gone");
    // touch entries 2 and 3 ahead of the hand: sweep skips them, takes 4
    expectHit(tagOf(2), 2, 0, 0, "R7 touch");
    expectHit(tagOf(3), 3, 0, 1, "R7 touch");
    doInsert(10'h3F2, 2);
    expectHit(10'h3F2, 4, 0, 2, "R7 sweep past set bits");
    expectHit(tagOf(2), 2, 1, 0, "R7 touched kept");
    expectHit(tagOf(3), 3, 1, 1, "R7 touched kept");
    expectMiss(tagOf(4), "R7 old entry 4 gone");
    doInsert(10'h3F3, 2);
    expectHit(10'h3F3, 5, 2, 2, "R7 hand advanced");
    expectHit(tagOf(6), 6, 0, 0, "R6 R7 entry 6 intact");
  endtask

  task automatic flushTest();
    @(negedge clk);
    lookupValid = 1'b0;
    flush = 1'b1; insertValid = 1'b1; insertTag = 10'h2AA; insertLine = lineOf(10'h2AA, 0);
    @(negedge clk);
    flush = 1'b0; insertValid = 1'b0;
    for (int i = 2; i < ENTRIES; i++) expectMiss(tagOf(i), "R8 flushed");
    expectMiss(10'h3F2, "R8 flushed");
    expectMiss(10'h2AA, "R8 insert dropped");
    doInsert(10'h111, 3);
    expectHit(10'h111, 0, 3, 3, "R4 R8 refill lowest");
    doInsert(10'h112, 3);
    expectHit(10'h112, 1, 0, 3, "R4 next lowest");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    resetTest();
    fillTest();
    gateTest();
    updateTest();
    clockTest();
    flushTest();
    idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule